// File: doc/BRIEF.md
# System Control Interrupt and Configuration Registers

This block is the system-control register file of a multi-function peripheral controller. It sits on an 8-bit data bus with an 8-bit byte offset, and its main job is to collect up to eight interrupt lines from sub-devices and present one masked interrupt to the host. The eight lines are assigned as follows: 0 is the flash controller, 1 is the card interface, 2 is the USB host, 3 is the serial port and 4 is the display. Lines 5 to 7 are spare.

Each line drives its own status bit, and that bit follows the line whenever the line changes level. Software can also overwrite the whole status byte. The block holds a fixed revision code and a routing byte. It also holds a set of 16-bit, 32-bit and three-element byte-array configuration registers. Software reads and writes these one byte at a time, low byte at the lowest offset. The configuration registers are storage only and control nothing inside the block.

The bus is simple. A write happens on a clock edge when `wr_en_i` is high. A read is combinational from `addr_i`.

Top module: `sysctl_irq_regs`

## Requirements
- R1: On a clock edge where a sub-interrupt line differs from its value at the previous edge, the matching status bit (offset 0x50) takes the new line level on that edge. A line that holds steady leaves its status bit unchanged.
- R2: A write to offset 0x50 overwrites the status byte. If a line changes on the same edge, the line level wins for that bit and the written value applies to all other bits.
- R3: `irq_o` is registered. After each edge it equals the OR of (status AND mask) as they stood before that edge. A 1 in the mask byte (offset 0x52) enables the matching source.
- R4: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to either offset are ignored.
- R5: The mask byte (0x52) and the routing byte (0x54) read back the last value written to them.
- R6: The 16-bit registers at 0x60, 0x8C, 0x90, 0x94, 0x98, 0x9A and 0xE4, and the 32-bit register at 0x9C, are little-endian: byte k sits at base+k. A byte write changes only the addressed byte.
- R7: The three-byte arrays at 0x64, 0x68, 0x6C, 0x70, 0x80, 0x84 and 0x88 hold one independently writable element per consecutive offset.
- R8: Any other offset reads 0x00, and a write to it changes no readable state. This includes 0x78–0x7A, 0x7C–0x7E and the gaps inside the map.
- R9: Reset (`rst_ni` low) clears status, mask, routing, all storage bytes and `irq_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| sub_irq_i | input | 8 | Sub-device interrupt levels |
| irq_o | output | 1 | Combined masked interrupt to host |

## Verification
The hardest case to reach is a status bit that disagrees with its line. A bit only follows its line when the line changes. So a line held high, with its bit then cleared by software, must leave both the bit and `irq_o` low until the line toggles again. The stimulus builds this directly. It raises a line, writes zero to status while the line holds, and confirms the bit stays clear. It also lines up a line change with a status write on the same edge, to show the line wins for that bit only. Long random runs then mix line toggles with status, mask and storage writes, so that these collisions and partial-lane writes recur at varied offsets.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int NUM_IRQ   = 8;
  localparam int MAX_BYTES = 4;
  localparam int NUM_BANKS = 15;

  localparam logic [AW-1:0] OFS_REV_LO = 8'h08;
  localparam logic [AW-1:0] OFS_REV_HI = 8'h09;
  localparam logic [AW-1:0] OFS_STAT   = 8'h50;
  localparam logic [AW-1:0] OFS_MASK   = 8'h52;
  localparam logic [AW-1:0] OFS_ROUTE  = 8'h54;
  localparam logic [DW-1:0] REV_CODE   = 8'h03;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [2:0]    nbytes;
  } bank_t;

  localparam bank_t BANKS [NUM_BANKS] = '{
    '{8'h60, 3'd2}, '{8'h64, 3'd3}, '{8'h68, 3'd3}, '{8'h6C, 3'd3},
    '{8'h70, 3'd3}, '{8'h80, 3'd3}, '{8'h84, 3'd3}, '{8'h88, 3'd3},
    '{8'h8C, 3'd2}, '{8'h90, 3'd2}, '{8'h94, 3'd2}, '{8'h98, 3'd2},
    '{8'h9A, 3'd2}, '{8'h9C, 3'd4}, '{8'hE4, 3'd2}
  };
endpackage

// File: rtl/irq_status.sv
module irq_status
  import sysctl_pkg::*;
#(
  parameter int N = NUM_IRQ
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sub_irq_i,
  input  logic         stat_we_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] line_q, status_q, mask_q, status_d;
  logic         irq_q;

  // line edge beats software write, per bit
  always_comb begin
    for (int b = 0; b < N; b++) begin
      if (sub_irq_i[b] != line_q[b]) status_d[b] = sub_irq_i[b];
      else if (stat_we_i)            status_d[b] = wdata_i[b];
      else                           status_d[b] = status_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= '0;
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      line_q   <= sub_irq_i;
      status_q <= status_d;
      if (mask_we_i) mask_q <= wdata_i;
      irq_q    <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  for (genvar b = 0; b < N; b++) begin : g_line_chk
    AST_LINE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sub_irq_i[b]) |=> status_q[b]); // R1
    AST_LINE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sub_irq_i[b]) |=> !status_q[b]); // R1
  end

  AST_SW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && sub_irq_i == line_q) |=> status_q == $past(wdata_i)); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) == '0) |=> !irq_o); // R3
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_we_i && sub_irq_i == line_q) |=> $stable(status_q)); // R1
endmodule

// File: rtl/byte_bank.sv
module byte_bank
  import sysctl_pkg::*;
#(
  parameter int BASE   = 8'h60,
  parameter int NBYTES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          hit_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] q [NBYTES];
  logic [NBYTES-1:0] lane_sel;

  for (genvar j = 0; j < NBYTES; j++) begin : g_lane
    assign lane_sel[j] = (int'(addr_i) == BASE + j);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q[j] <= '0;
      else if (we_i && lane_sel[j]) q[j] <= wdata_i;
    end

    AST_LANE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && lane_sel[j]) |=> $stable(q[j])); // R6
    AST_LANE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && lane_sel[j]) |=> q[j] == $past(wdata_i)); // R7
  end

  assign hit_o = |lane_sel;

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < NBYTES; j++)
      if (lane_sel[j]) rdata_o = q[j];
  end
endmodule

// File: rtl/sysctl_irq_regs.sv
module sysctl_irq_regs
  import sysctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_IRQ-1:0] sub_irq_i,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] status, mask;
  logic [DW-1:0]      route_q;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [DW-1:0]      bank_rd [NUM_BANKS];
  logic [DW-1:0]      bank_or;
  logic               ctl_hit;

  irq_status #(.N(NUM_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sub_irq_i (sub_irq_i),
    .stat_we_i (wr_en_i && addr_i == OFS_STAT),
    .mask_we_i (wr_en_i && addr_i == OFS_MASK),
    .wdata_i   (wdata_i[NUM_IRQ-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              route_q <= '0;
    else if (wr_en_i && addr_i == OFS_ROUTE)  route_q <= wdata_i;
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    byte_bank #(
      .BASE   (int'(BANKS[k].base)),
      .NBYTES (int'(BANKS[k].nbytes))
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .hit_o   (bank_hit[k]),
      .rdata_o (bank_rd[k])
    );
  end

  always_comb begin
    bank_or = '0;
    for (int k = 0; k < NUM_BANKS; k++) bank_or |= bank_rd[k];
  end

  assign ctl_hit = (addr_i == OFS_REV_LO) || (addr_i == OFS_REV_HI) ||
                   (addr_i == OFS_STAT) || (addr_i == OFS_MASK) || (addr_i == OFS_ROUTE);

  always_comb begin
    unique case (addr_i)
      OFS_REV_LO: rdata_o = REV_CODE;
      OFS_REV_HI: rdata_o = '0;
      OFS_STAT:   rdata_o = DW'(status);
      OFS_MASK:   rdata_o = DW'(mask);
      OFS_ROUTE:  rdata_o = route_q;
      default:    rdata_o = bank_or;
    endcase
  end

  AST_REV_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_REV_LO) |-> rdata_o == 8'h03); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_hit && bank_hit == '0) |-> rdata_o == '0); // R8
  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit)); // R6
  AST_ROUTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFS_ROUTE) |=> $stable(route_q)); // R5
endmodule

// File: tb/sysctl_irq_regs_tb.sv
module sysctl_irq_regs_tb;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, sub = '0;
  logic [7:0] rdata;
  logic       irq;

  sysctl_irq_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sub_irq_i(sub), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m_store [256];
  logic [7:0] m_status = '0, m_mask = '0, m_route = '0, m_prev = '0;
  logic       m_irq = 1'b0;

  function automatic bit is_store(logic [7:0] a);
    return (a >= 8'h60 && a <= 8'h61) || (a >= 8'h64 && a <= 8'h66) ||
           (a >= 8'h68 && a <= 8'h6A) || (a >= 8'h6C && a <= 8'h6E) ||
           (a >= 8'h70 && a <= 8'h72) || (a >= 8'h80 && a <= 8'h82) ||
           (a >= 8'h84 && a <= 8'h86) || (a >= 8'h88 && a <= 8'h8A) ||
           (a >= 8'h8C && a <= 8'h8D) || (a >= 8'h90 && a <= 8'h91) ||
           (a >= 8'h94 && a <= 8'h95) || (a >= 8'h98 && a <= 8'h9F) ||
           (a >= 8'hE4 && a <= 8'hE5);
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h08) return 8'h03;
    if (a == 8'h09) return 8'h00;
    if (a == 8'h50) return m_status;
    if (a == 8'h52) return m_mask;
    if (a == 8'h54) return m_route;
    if (is_store(a)) return m_store[a];
    return 8'h00;
  endfunction

  function automatic string req_of(logic [7:0] a);
    if (a == 8'h08 || a == 8'h09) return "R4";
    if (a == 8'h50) return "R1/R2";
    if (a == 8'h52 || a == 8'h54) return "R5";
    if ((a >= 8'h64 && a <= 8'h72) || (a >= 8'h80 && a <= 8'h8A)) return "R7";
    if (is_store(a)) return "R6";
    return "R8";
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step(bit w, logic [7:0] a, logic [7:0] d, logic [7:0] s);
    logic nxt_irq;
    we = w; addr = a; wdata = d; sub = s;
    @(posedge clk);
    nxt_irq = |(m_status & m_mask);
    for (int b = 0; b < 8; b++) begin
      if (s[b] != m_prev[b])       m_status[b] = s[b];
      else if (w && a == 8'h50)    m_status[b] = d[b];
    end
    if (w && a == 8'h52) m_mask = d;
    if (w && a == 8'h54) m_route = d;
    if (w && is_store(a)) m_store[a] = d;
    m_prev = s;
    m_irq = nxt_irq;
    @(negedge clk);
    chk("R3", int'(irq), int'(m_irq));
    chk(req_of(a), int'(rdata), int'(exp_read(a)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) m_store[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    chk("R9", int'(irq), 0);
    for (int a = 0; a < 256; a += 1) begin
      addr = 8'(a); #1;
      chk("R9", int'(rdata), (a == 8'h08) ? 3 : 0);
    end
    @(negedge clk);
    // R4: revision writes ignored
    step(1, 8'h08, 8'hAA, 8'h00);
    step(1, 8'h09, 8'h55, 8'h00);
    // R6: single lane of 32-bit register
    step(1, 8'h9C, 8'h11, 8'h00); step(1, 8'h9D, 8'h22, 8'h00);
    step(1, 8'h9E, 8'h33, 8'h00); step(1, 8'h9F, 8'h44, 8'h00);
    step(1, 8'h9D, 8'hEE, 8'h00);
    step(0, 8'h9C, 8'h00, 8'h00); step(0, 8'h9E, 8'h00, 8'h00);
    // R8: unmapped writes do not alter anything
    step(1, 8'h78, 8'hFF, 8'h00); step(1, 8'h7C, 8'hFF, 8'h00);
    step(0, 8'h78, 8'h00, 8'h00); step(0, 8'h62, 8'h00, 8'h00);
    // R1/R3: raise line 3 with mask enabled, irq one edge after status
    step(1, 8'h52, 8'h08, 8'h00);
    step(0, 8'h50, 8'h00, 8'h08);
    step(0, 8'h50, 8'h00, 8'h08);
    // R2: software clears status while line holds high; stays clear
    step(1, 8'h50, 8'h00, 8'h08);
    step(0, 8'h50, 8'h00, 8'h08);
    step(0, 8'h50, 8'h00, 8'h08);
    // R2: line 0 rises while software writes 0xF0: line wins for bit 0
    step(1, 8'h50, 8'hF0, 8'h09);
    step(0, 8'h50, 8'h00, 8'h09);
    // R1: falling line clears bit
    step(0, 8'h50, 8'h00, 8'h00);
    step(1, 8'h54, 8'h5A, 8'h00);
    step(0, 8'h54, 8'h00, 8'h00);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a, d, s;
      int sel;
      sel = int'($urandom_range(0, 9));
      d = 8'($urandom);
      s = sub;
      if ($urandom_range(0, 3) == 0) s = s ^ (8'h1 << $urandom_range(0, 7));
      case (sel)
        0, 1: a = 8'h50;
        2:    a = 8'h52;
        3:    a = 8'($urandom);
        default: begin
          a = 8'($urandom);
          while (!is_store(a)) a = 8'($urandom);
        end
      endcase
      step(bit'($urandom_range(0, 1)), a, d, s);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule